// File: doc/BRIEF.md
# UART Receive Buffer with Automatic RTS

This block sits between the receive shift register of a UART and the host. Each finished character arrives as 8 data bits plus 3 error bits (parity, framing, break). The block stores the character and its error bits together in a 16-entry buffer. The oldest character is presented on a holding-register port, and its error bits appear in a line-status view only once that character is at the head. In single-register mode the buffer shrinks to one entry.

A receive interrupt rises once the fill reaches a selectable trigger level. An active-low RTS output throttles the remote sender with hysteresis. It goes high when the fill climbs past an upper threshold and returns low when the fill falls below a lower one, both placed around the trigger.

The input side is a valid/ready stream. The shift register cannot stall, so a character offered while `rx_ready` is low is discarded and recorded as an overrun; it is never held for retry. On the output side, `hold_valid` means a character is at the head. Asserting `hold_ready` while `hold_valid` is high consumes it on that clock edge.

Top module: `uart_rx_fifo_rts`

## Requirements
- R1: A character is accepted on a rising edge where `rx_valid` and `rx_ready` are both high. `rx_ready` is high while the fill is below the capacity, which is 16 in buffered mode (`fifo_en`=1) and 1 in single-register mode.
- R2: Characters leave in arrival order. `hold_data` always shows the oldest stored character, and up to 16 are held.
- R3: `line_status[4:2]` shows the head character's error bits: bit 2 parity, bit 3 framing, bit 4 break (from `rx_err[0]`, `[1]`, `[2]`). After a consuming read they change on the same edge to the next character's bits. They read 0 when the buffer is empty.
- R4: A character offered while `rx_ready` is low is dropped and sets `line_status[1]`. That bit stays set until an edge with `status_rd` high clears it. A new drop on that same edge keeps it set.
- R5: `line_status[0]` and `hold_valid` are high exactly when at least one character is stored.
- R6: `rx_irq` is high while the fill is at least the trigger. `trig_sel` 0/1/2/3 selects 1/4/8/14. In single-register mode the trigger is 1.
- R7: With `afc_en` and `mcr_rts` both high, `rts_n` goes high on the edge where the fill becomes greater than hi = min(T+4, capacity-1). It goes low on the edge where the fill becomes less than lo = max(T-4, 1). It holds between the two. With T=8 this gives hi=12 and lo=4.
- R8: In single-register mode a second character arriving before the first is read is an overrun, and the first character is kept.
- R9: When automatic RTS is not enabled, `rts_n` equals the inverse of `mcr_rts`.
- R10: A read (`hold_ready`) while `hold_valid` is low has no effect on the stored contents.
- R11: A change of `fifo_en` empties the buffer on the next edge. A character offered in that cycle is dropped without flagging an overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_en | input | 1 | 1 = 16-entry buffer, 0 = single register |
| trig_sel | input | 2 | Interrupt trigger select |
| afc_en | input | 1 | Automatic flow-control enable |
| mcr_rts | input | 1 | Modem-control RTS request |
| rx_valid | input | 1 | Character from shift register is valid |
| rx_ready | output | 1 | Buffer can accept a character |
| rx_data | input | 8 | Received data byte |
| rx_err | input | 3 | Error bits: [0] parity, [1] framing, [2] break |
| hold_valid | output | 1 | A character is at the head |
| hold_ready | input | 1 | Host consumes the head character |
| hold_data | output | 8 | Head character data |
| status_rd | input | 1 | Status read strobe, clears overrun |
| line_status | output | 5 | {err tags[4:2], overrun, data ready} |
| rx_irq | output | 1 | Receive-data interrupt |
| rts_n | output | 1 | Active-low request-to-send |

## Verification
The hardest situation to reach is the RTS hysteresis band. The fill must rise past the upper threshold and then be drained back through the whole band without `rts_n` changing, before it finally drops below the lower threshold. The stimulus gets there with trigger 8: it writes 12 characters and then a 13th, reads down to 4 while checking that RTS stays deasserted, and makes one more read. Overrun is reached by filling all 16 entries and offering a 17th. The check then confirms that the head character and its tags are untouched.

// File: rtl/uart_rxf_pkg.sv
package uart_rxf_pkg;
  localparam int CHAR_W = 8;
  localparam int ERR_W  = 3;
  localparam int ENTRY_W = CHAR_W + ERR_W;

  // trigger levels scale with depth: 1, depth/4, depth/2, depth-2
  function automatic int unsigned trig_level(input logic [1:0] sel, input int unsigned depth);
    case (sel)
      2'd0:    return 1;
      2'd1:    return depth / 4;
      2'd2:    return depth / 2;
      default: return depth - 2;
    endcase
  endfunction
endpackage

// File: rtl/uart_rxf_store.sv
module uart_rxf_store #(
  parameter int W     = 11,
  parameter int DEPTH = 16,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic [CW-1:0] cap,
  input  logic          wr_req,
  input  logic [W-1:0]  wr_data,
  input  logic          rd_req,
  output logic [W-1:0]  head,
  output logic [CW-1:0] fill,
  output logic [CW-1:0] fill_next,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic          wr_ok, rd_ok;

  assign full  = (fill >= cap);
  assign empty = (fill == '0);
  assign wr_ok = wr_req & ~full & ~flush;
  assign rd_ok = rd_req & ~empty & ~flush;
  assign head  = mem[rp];

  always_comb begin
    if (flush) fill_next = '0;
    else       fill_next = fill + CW'(wr_ok) - CW'(rd_ok);
  end

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp   <= '0;
      rp   <= '0;
      fill <= '0;
    end else begin
      fill <= fill_next;
      if (flush) begin
        wp <= '0;
        rp <= '0;
      end else begin
        if (wr_ok) wp <= bump(wp);
        if (rd_ok) rp <= bump(rp);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wp] <= wr_data;
  end
endmodule

// File: rtl/uart_rxf_flow.sv
module uart_rxf_flow #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] fill,
  input  logic [CW-1:0] fill_next,
  input  logic [CW-1:0] trig,
  input  logic [CW-1:0] cap,
  input  logic          auto_en,
  input  logic          mcr_rts,
  output logic          rx_irq,
  output logic          rts_n
);
  localparam int XW = CW + 1;
  logic [XW-1:0] t_x, up_raw, top, hi, lo;
  logic          stop_q;

  assign t_x    = XW'(trig);
  assign up_raw = t_x + XW'(4);
  assign top    = XW'(cap) - XW'(1);
  assign hi     = (up_raw > top) ? top : up_raw;
  assign lo     = (t_x > XW'(5)) ? (t_x - XW'(4)) : XW'(1);

  assign rx_irq = (fill >= trig);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stop_q <= 1'b0;
    end else if (XW'(fill_next) > hi) begin
      stop_q <= 1'b1;
    end else if (XW'(fill_next) < lo) begin
      stop_q <= 1'b0;
    end
  end

  assign rts_n = auto_en ? stop_q : ~mcr_rts;
endmodule

// File: rtl/uart_rx_fifo_rts.sv
module uart_rx_fifo_rts
  import uart_rxf_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fifo_en,
  input  logic [1:0]        trig_sel,
  input  logic              afc_en,
  input  logic              mcr_rts,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [CHAR_W-1:0] rx_data,
  input  logic [ERR_W-1:0]  rx_err,
  output logic              hold_valid,
  input  logic              hold_ready,
  output logic [CHAR_W-1:0] hold_data,
  input  logic              status_rd,
  output logic [4:0]        line_status,
  output logic              rx_irq,
  output logic              rts_n
);
  localparam int CW = $clog2(DEPTH + 1);

  logic               mode_q, flush, full, empty, drop, ovr_q;
  logic [CW-1:0]      cap, teff, fill, fill_next;
  logic [ENTRY_W-1:0] head;
  logic [ERR_W-1:0]   tags;

  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= 1'b0;
    else        mode_q <= fifo_en;
  end

  assign flush = (mode_q != fifo_en);
  assign cap   = fifo_en ? CW'(DEPTH) : CW'(1);
  assign teff  = fifo_en ? CW'(trig_level(trig_sel, DEPTH)) : CW'(1);

  uart_rxf_store #(.W(ENTRY_W), .DEPTH(DEPTH)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush),
    .cap      (cap),
    .wr_req   (rx_valid),
    .wr_data  ({rx_err, rx_data}),
    .rd_req   (hold_ready),
    .head     (head),
    .fill     (fill),
    .fill_next(fill_next),
    .full     (full),
    .empty    (empty)
  );

  assign rx_ready = ~full;
  assign drop     = rx_valid & full & ~flush;

  always_ff @(posedge clk) begin
    if (!rst_n)         ovr_q <= 1'b0;
    else if (drop)      ovr_q <= 1'b1;
    else if (status_rd) ovr_q <= 1'b0;
  end

  assign hold_valid  = ~empty;
  assign hold_data   = head[CHAR_W-1:0];
  assign tags        = empty ? '0 : head[ENTRY_W-1:CHAR_W];
  assign line_status = {tags, ovr_q, hold_valid};

  uart_rxf_flow #(.CW(CW)) u_flow (
    .clk      (clk),
    .rst_n    (rst_n),
    .fill     (fill),
    .fill_next(fill_next),
    .trig     (teff),
    .cap      (cap),
    .auto_en  (afc_en & mcr_rts),
    .mcr_rts  (mcr_rts),
    .rx_irq   (rx_irq),
    .rts_n    (rts_n)
  );
endmodule

// File: rtl/uart_rx_fifo_rts_chk.sv
module uart_rx_fifo_rts_chk #(
  parameter int DEPTH = 16,
  parameter int CW    = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rx_valid,
  input logic          rx_ready,
  input logic          hold_valid,
  input logic          hold_ready,
  input logic [4:0]    line_status,
  input logic          rx_irq,
  input logic          rts_n,
  input logic          afc_en,
  input logic          mcr_rts,
  input logic [CW-1:0] fill,
  input logic          flush
);
  a_r2_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= CW'(DEPTH));
  a_r1_ready_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_ready |-> fill != '0);
  a_r4_overrun_set: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready && !flush) |=> line_status[1]);
  a_r3_empty_tags: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_valid |-> line_status[4:2] == 3'b000);
  a_r6_irq_has_data: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> hold_valid);
  a_r10_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_ready && !hold_valid && !rx_valid && !flush) |=> fill == $past(fill));
  a_r7_rts_rise_data: assert property (@(posedge clk) disable iff (!rst_n)
    (afc_en && mcr_rts && $past(afc_en && mcr_rts) && $rose(rts_n)) |-> hold_valid);
  a_r11_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> fill == '0);
endmodule

bind uart_rx_fifo_rts uart_rx_fifo_rts_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rx_valid   (rx_valid),
  .rx_ready   (rx_ready),
  .hold_valid (hold_valid),
  .hold_ready (hold_ready),
  .line_status(line_status),
  .rx_irq     (rx_irq),
  .rts_n      (rts_n),
  .afc_en     (afc_en),
  .mcr_rts    (mcr_rts),
  .fill       (fill),
  .flush      (flush)
);

// File: tb/uart_rx_fifo_rts_bench.sv
module uart_rx_fifo_rts_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fifo_en = 1'b1;
  logic [1:0] trig_sel = 2'd0;
  logic       afc_en = 1'b0, mcr_rts = 1'b0;
  logic       rx_valid = 1'b0, hold_ready = 1'b0, status_rd = 1'b0;
  logic [7:0] rx_data = '0;
  logic [2:0] rx_err = '0;
  logic       rx_ready, hold_valid, rx_irq, rts_n;
  logic [7:0] hold_data;
  logic [4:0] line_status;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  always #5 clk = ~clk;

  uart_rx_fifo_rts u_uart_rx_fifo_rts (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .trig_sel(trig_sel),
    .afc_en(afc_en), .mcr_rts(mcr_rts), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_data(rx_data), .rx_err(rx_err), .hold_valid(hold_valid),
    .hold_ready(hold_ready), .hold_data(hold_data), .status_rd(status_rd),
    .line_status(line_status), .rx_irq(rx_irq), .rts_n(rts_n)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] d, input logic [2:0] e);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = d; rx_err = e;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic pop();
    @(negedge clk);
    hold_ready = 1'b1;
    @(negedge clk);
    hold_ready = 1'b0;
  endtask

  task automatic read_status();
    @(negedge clk);
    status_rd = 1'b1;
    @(negedge clk);
    status_rd = 1'b0;
  endtask

  task automatic drain();
    while (hold_valid) pop();
  endtask

  task automatic t_reset();
    check(hold_valid == 0, "R5 reset empty", hold_valid, 0);
    check(line_status == 0, "R3 reset status", line_status, 0);
    check(rx_irq == 0, "R6 reset irq", rx_irq, 0);
    check(rts_n == 1, "R9 reset rts_n", rts_n, 1);
    check(rx_ready == 1, "R1 reset ready", rx_ready, 1);
  endtask

  task automatic t_order_tags();
    push(8'hA1, 3'b001); push(8'hB2, 3'b010); push(8'hC3, 3'b100);
    check(hold_data == 8'hA1, "R2 head first", hold_data, 8'hA1);
    check(line_status[4:2] == 3'b001, "R3 parity tag", line_status[4:2], 1);
    check(line_status[0] == 1, "R5 data ready", line_status[0], 1);
    pop();
    check(hold_data == 8'hB2, "R2 second", hold_data, 8'hB2);
    check(line_status[4:2] == 3'b010, "R3 framing tag", line_status[4:2], 2);
    pop();
    check(hold_data == 8'hC3, "R2 third", hold_data, 8'hC3);
    check(line_status[4:2] == 3'b100, "R3 break tag", line_status[4:2], 4);
    pop();
    check(hold_valid == 0, "R5 empty after drain", hold_valid, 0);
    check(line_status[4:2] == 0, "R3 tags zero empty", line_status[4:2], 0);
  endtask

  task automatic t_trigger();
    trig_sel = 2'd2;
    for (int i = 0; i < 7; i++) push(8'(i), 3'b000);
    check(rx_irq == 0, "R6 below trigger", rx_irq, 0);
    push(8'h07, 3'b000);
    check(rx_irq == 1, "R6 at trigger", rx_irq, 1);
    pop();
    check(rx_irq == 0, "R6 back below", rx_irq, 0);
    drain();
  endtask

  task automatic t_auto_rts();
    trig_sel = 2'd2; afc_en = 1'b1; mcr_rts = 1'b1;
    @(negedge clk);
    check(rts_n == 0, "R7 empty asserted", rts_n, 0);
    for (int i = 0; i < 12; i++) push(8'(i), 3'b000);
    check(rts_n == 0, "R7 at 12 still low", rts_n, 0);
    push(8'h0C, 3'b000);
    check(rts_n == 1, "R7 above 12 high", rts_n, 1);
    for (int i = 0; i < 9; i++) pop();
    check(rts_n == 1, "R7 hold in band at 4", rts_n, 1);
    pop();
    check(rts_n == 0, "R7 below 4 low", rts_n, 0);
    drain();
    afc_en = 1'b0;
  endtask

  task automatic t_manual_rts();
    afc_en = 1'b0; mcr_rts = 1'b1;
    for (int i = 0; i < 14; i++) push(8'(i), 3'b000);
    check(rts_n == 0, "R9 manual low despite fill", rts_n, 0);
    mcr_rts = 1'b0;
    @(negedge clk);
    check(rts_n == 1, "R9 manual high", rts_n, 1);
    drain();
  endtask

  task automatic t_overrun();
    for (int i = 0; i < 16; i++) push(8'h40 + 8'(i), 3'b010);
    check(rx_ready == 0, "R1 full not ready", rx_ready, 0);
    check(line_status[1] == 0, "R4 no overrun yet", line_status[1], 0);
    push(8'hEE, 3'b100);
    check(line_status[1] == 1, "R4 overrun set", line_status[1], 1);
    check(hold_data == 8'h40, "R4 head kept", hold_data, 8'h40);
    check(line_status[4:2] == 3'b010, "R4 head tags kept", line_status[4:2], 2);
    read_status();
    check(line_status[1] == 0, "R4 overrun cleared", line_status[1], 0);
    for (int i = 0; i < 15; i++) pop();
    check(hold_data == 8'h4F, "R2 sixteenth entry", hold_data, 8'h4F);
    pop();
    check(hold_valid == 0, "R4 dropped not stored", hold_valid, 0);
  endtask

  task automatic t_empty_read();
    pop(); pop();
    push(8'h5A, 3'b000);
    check(hold_data == 8'h5A, "R10 empty read no effect", hold_data, 8'h5A);
    pop();
    check(hold_valid == 0, "R10 single entry", hold_valid, 0);
  endtask

  task automatic t_mode_flush();
    push(8'h11, 3'b000); push(8'h22, 3'b000);
    @(negedge clk);
    fifo_en = 1'b0;
    @(negedge clk);
    check(hold_valid == 0, "R11 flush on mode change", hold_valid, 0);
    check(line_status[1] == 0, "R11 no overrun", line_status[1], 0);
  endtask

  task automatic t_single_reg();
    push(8'h77, 3'b001);
    check(rx_ready == 0, "R8 single full", rx_ready, 0);
    check(rx_irq == 1, "R6 single trigger 1", rx_irq, 1);
    push(8'h88, 3'b000);
    check(line_status[1] == 1, "R8 second is overrun", line_status[1], 1);
    check(hold_data == 8'h77, "R8 first kept", hold_data, 8'h77);
    read_status();
    pop();
    check(hold_valid == 0, "R8 empty after read", hold_valid, 0);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_order_tags();
    t_trigger();
    t_auto_rts();
    t_manual_rts();
    t_overrun();
    t_empty_read();
    t_mode_flush();
    t_single_reg();
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule